// File: doc/BRIEF.md
# Two-Rank Byte-Loadable Converter Code Register

This block holds the 16-bit code that drives a digital-to-analog converter. It has two ranks. The first rank is a pair of byte holders, one for the upper byte and one for the lower byte. Each byte holder is written when the chip select and its own byte enable are both low. The second rank is the full-width code register that feeds the converter. It takes a copy of the first rank while the chip select and the update strobe are both low. All controls are active-low and act on their level, not on an edge.

A host on an 8-bit bus writes the two bytes in two cycles. It can tie the update strobe to the enable of whichever byte it writes second, so the code register loads in the same cycle as that byte. A host on a 16-bit bus enables both bytes at once. When all controls are low, the bus passes straight through to the code register, which then acts as a single 16-bit register.

Several of these blocks can be filled one at a time and then driven by one shared update strobe, so that all their codes change in the same cycle.

For synthesis, each latch is modelled as a register with a clock enable. A rank samples on every rising clock edge while its enable is held. The code register samples the value the first rank is about to take, so bus data loaded together with an update reaches the output after one edge.

Top module: `dbr_code_reg`

## Requirements
- R1: While sel_n is high, no clock edge changes either rank, whatever the other controls and the bus do.
- R2: With sel_n low and hi_en_n, lo_en_n and upd_n all high, no clock edge changes either rank.
- R3: With sel_n=0, hi_en_n=0, lo_en_n=1, upd_n=1, a clock edge loads bus_in[15:8] into the upper byte of the first rank. The lower byte of the first rank and code_out do not change.
- R4: With sel_n=0, hi_en_n=1, lo_en_n=0, upd_n=1, a clock edge loads bus_in[7:0] into the lower byte of the first rank. The upper byte and code_out do not change.
- R5: With sel_n=0, hi_en_n=1, lo_en_n=1, upd_n=0, a clock edge copies the first rank into code_out: upper byte to code_out[15:8], lower byte to code_out[7:0]. The first rank does not change.
- R6: With all four controls low, a clock edge puts bus_in into both the first rank and code_out. The value is held after the controls return high.
- R7: A clock edge with rst_n low clears both ranks to 0x0000.
- R8: When upd_n is low together with exactly one byte enable, code_out takes the new bus byte in that byte's position and the held first-rank byte in the other position, all at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_n | input | 1 | Chip select, active low |
| hi_en_n | input | 1 | Upper byte enable, active low |
| lo_en_n | input | 1 | Lower byte enable, active low |
| upd_n | input | 1 | Code register load strobe, active low |
| bus_in | input | 16 | Data bus |
| code_out | output | 16 | Code presented to the converter |

## Verification
The assertions assume that every control and bus_in settle between clock edges. Each control combination is then judged only by what was present at the last edge.

The stimulus changes its inputs only on the falling clock edge. It holds each combination for exactly one rising edge before the next one is applied. This keeps every property's antecedent tied to one known control pattern.

Contents of the first rank that the output does not show are brought out by a later update-only cycle. The bench then compares the result with literal expected codes.

// File: rtl/dbr_pkg.sv
// Shared definitions for the two-rank code register.
// Assumes the first rank has exactly two byte lanes: lane 0 is the low byte, lane 1 the high byte.
package dbr_pkg;
    localparam int LANES   = 2;
    localparam int LANE_LO = 0;
    localparam int LANE_HI = 1;

    // Controls decoded to active-high write enables.
    typedef struct packed {
        logic hi_we;
        logic lo_we;
        logic upd_we;
    } dbr_we_t;

    // Convert the active-low control pins into active-high enables.
    function automatic dbr_we_t decode_ctrl(input logic sel_n, input logic hi_n,
                                            input logic lo_n, input logic upd_n);
        dbr_we_t w;
        w.hi_we  = !sel_n && !hi_n;
        w.lo_we  = !sel_n && !lo_n;
        w.upd_we = !sel_n && !upd_n;
        return w;
    endfunction
endpackage

// File: rtl/dbr_ctrl_decode.sv
// Control decoder: turns the four active-low level controls into one write
// enable per byte lane and one update enable.
// Assumes the controls are stable around each rising clock edge.
module dbr_ctrl_decode
    import dbr_pkg::*;
(
    input  logic             sel_n,
    input  logic             hi_en_n,
    input  logic             lo_en_n,
    input  logic             upd_n,
    output logic [LANES-1:0] lane_we,
    output logic             upd_we
);
    dbr_we_t we;

    // Decode the control levels into active-high enables.
    always_comb begin
        we               = decode_ctrl(sel_n, hi_en_n, lo_en_n, upd_n);
        lane_we          = '0;
        lane_we[LANE_HI] = we.hi_we;
        lane_we[LANE_LO] = we.lo_we;
        upd_we           = we.upd_we;
    end
endmodule

// File: rtl/dbr_byte_rank.sv
// First rank: one enabled register per byte lane.
// Each lane samples its slice of the bus on every edge while its enable is held.
// The output rank_next gives the value the rank takes at the coming edge, so the
// second rank can pass data through in the same cycle.
// Assumes a synchronous active-low reset.
module dbr_byte_rank #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 2,
    localparam int DATA_W = BYTE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  lane_we,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] rank_q,
    output logic [DATA_W-1:0] rank_next
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Select the new bus byte when this lane is enabled, otherwise keep it.
        always_comb begin
            rank_next[g*BYTE_W +: BYTE_W] = lane_we[g] ? bus_in[g*BYTE_W +: BYTE_W]
                                                       : rank_q[g*BYTE_W +: BYTE_W];
        end

        // Hold this lane's byte, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) rank_q[g*BYTE_W +: BYTE_W] <= '0;
            else        rank_q[g*BYTE_W +: BYTE_W] <= rank_next[g*BYTE_W +: BYTE_W];
        end
    end
endmodule

// File: rtl/dbr_dac_stage.sv
// Second rank: the full-width code register that drives the converter.
// While upd_we is held it copies the first rank's next value on every edge.
// Assumes a synchronous active-low reset.
module dbr_dac_stage #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_we,
    input  logic [DATA_W-1:0] src,
    output logic [DATA_W-1:0] code_q
);
    // Load the code from the first rank while the update is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)      code_q <= '0;
        else if (upd_we) code_q <= src;
    end
endmodule

// File: rtl/dbr_code_reg.sv
// Top level: two-rank, byte-loadable converter code register.
// The first rank holds the high and low bytes. The second rank holds the code
// sent to the converter.
// Assumes all controls and the bus are synchronous to clk.
module dbr_code_reg #(
    parameter int BYTE_W = 8,
    localparam int DATA_W = BYTE_W * dbr_pkg::LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              hi_en_n,
    input  logic              lo_en_n,
    input  logic              upd_n,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] code_out
);
    logic [dbr_pkg::LANES-1:0] lane_we;
    logic                      upd_we;
    logic [DATA_W-1:0]         rank_q;
    logic [DATA_W-1:0]         rank_next;

    dbr_ctrl_decode u_dec (
        .sel_n   (sel_n),
        .hi_en_n (hi_en_n),
        .lo_en_n (lo_en_n),
        .upd_n   (upd_n),
        .lane_we (lane_we),
        .upd_we  (upd_we)
    );

    dbr_byte_rank #(.BYTE_W(BYTE_W), .LANES(dbr_pkg::LANES)) u_rank (
        .clk       (clk),
        .rst_n     (rst_n),
        .lane_we   (lane_we),
        .bus_in    (bus_in),
        .rank_q    (rank_q),
        .rank_next (rank_next)
    );

    dbr_dac_stage #(.DATA_W(DATA_W)) u_dac (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd_we (upd_we),
        .src    (rank_next),
        .code_q (code_out)
    );
endmodule

// File: rtl/dbr_code_reg_chk.sv
// Checker for dbr_code_reg: relates the control pins, the bus, the first rank
// and the code output across one clock edge.
// Assumes the inputs are stable at each rising edge.
module dbr_code_reg_chk #(
    parameter int BYTE_W = 8,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_n,
    input logic              hi_en_n,
    input logic              lo_en_n,
    input logic              upd_n,
    input logic [DATA_W-1:0] bus_in,
    input logic [DATA_W-1:0] rank_q,
    input logic [DATA_W-1:0] code_out
);
    localparam int HI = DATA_W - 1;
    localparam int LH = BYTE_W;
    localparam int LT = BYTE_W - 1;

    p_sel_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> (rank_q == $past(rank_q)) && (code_out == $past(code_out)));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && hi_en_n && lo_en_n && upd_n)
        |=> (rank_q == $past(rank_q)) && (code_out == $past(code_out)));

    p_hi_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !hi_en_n && lo_en_n && upd_n)
        |=> (rank_q[HI:LH] == $past(bus_in[HI:LH])) && (rank_q[LT:0] == $past(rank_q[LT:0]))
            && (code_out == $past(code_out)));

    p_lo_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && hi_en_n && !lo_en_n && upd_n)
        |=> (rank_q[LT:0] == $past(bus_in[LT:0])) && (rank_q[HI:LH] == $past(rank_q[HI:LH]))
            && (code_out == $past(code_out)));

    p_update_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && hi_en_n && lo_en_n && !upd_n)
        |=> (code_out == $past(rank_q)) && (rank_q == $past(rank_q)));

    p_transparent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !hi_en_n && !lo_en_n && !upd_n)
        |=> (code_out == $past(bus_in)) && (rank_q == $past(bus_in)));

    p_reset_clear_r7: assert property (@(posedge clk)
        !rst_n |=> (code_out == '0) && (rank_q == '0));

    p_tied_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !hi_en_n && lo_en_n && !upd_n)
        |=> (code_out[HI:LH] == $past(bus_in[HI:LH])) && (code_out[LT:0] == $past(rank_q[LT:0])));

    p_tied_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && hi_en_n && !lo_en_n && !upd_n)
        |=> (code_out[LT:0] == $past(bus_in[LT:0])) && (code_out[HI:LH] == $past(rank_q[HI:LH])));
endmodule

bind dbr_code_reg dbr_code_reg_chk #(.BYTE_W(BYTE_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_n    (sel_n),
    .hi_en_n  (hi_en_n),
    .lo_en_n  (lo_en_n),
    .upd_n    (upd_n),
    .bus_in   (bus_in),
    .rank_q   (rank_q),
    .code_out (code_out)
);

// File: tb/dbr_code_reg_test.sv
`timescale 1ns/1ps
// Directed bench for dbr_code_reg. Inputs change on the falling edge and the
// output is sampled 1 ns after the rising edge.
module dbr_code_reg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1;
    logic        hi_en_n = 1'b1;
    logic        lo_en_n = 1'b1;
    logic        upd_n = 1'b1;
    logic [15:0] bus_in = 16'h0000;
    logic [15:0] code_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dbr_code_reg uut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .hi_en_n(hi_en_n),
        .lo_en_n(lo_en_n), .upd_n(upd_n), .bus_in(bus_in), .code_out(code_out)
    );

    // Apply one control pattern for exactly one rising edge, then sample.
    task automatic step(input logic s, input logic h, input logic l, input logic u,
                        input logic [15:0] d);
        @(negedge clk);
        sel_n = s; hi_en_n = h; lo_en_n = l; upd_n = u; bus_in = d;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [15:0] exp);
        checks++;
        if (code_out !== exp) begin
            errors++;
            $display("FAIL %s code_out=%h expected=%h", req, code_out, exp);
        end
    endtask

    // Reveal the first rank through an update-only cycle.
    task automatic reveal(input string req, input logic [15:0] exp);
        step(1'b0, 1'b1, 1'b1, 1'b0, 16'hDEAD);
        check(req, exp);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        step(1'b0, 1'b0, 1'b0, 1'b0, 16'hBEEF);
        check("R7 reset clears code", 16'h0000);
        rst_n = 1'b1;
        reveal("R7 reset clears first rank", 16'h0000);
    endtask

    task automatic t_hi_byte;
        step(1'b0, 1'b0, 1'b1, 1'b1, 16'hA5C3);
        check("R3 code unchanged by high byte load", 16'h0000);
        reveal("R3 high byte loaded", 16'hA500);
    endtask

    task automatic t_lo_byte;
        step(1'b0, 1'b1, 1'b0, 1'b1, 16'h113C);
        check("R4 code unchanged by low byte load", 16'hA500);
        reveal("R4 low byte loaded, high kept", 16'hA53C);
    endtask

    task automatic t_update_only;
        step(1'b0, 1'b1, 1'b1, 1'b0, 16'h0000);
        check("R5 update copies rank, ignores bus", 16'hA53C);
        step(1'b0, 1'b1, 1'b1, 1'b0, 16'hFFFF);
        check("R5 repeated update keeps rank", 16'hA53C);
    endtask

    task automatic t_sel_block;
        step(1'b1, 1'b0, 1'b0, 1'b0, 16'h5A5A);
        check("R1 deselected: code held", 16'hA53C);
        step(1'b1, 1'b0, 1'b1, 1'b1, 16'h7777);
        check("R1 deselected high write: code held", 16'hA53C);
        reveal("R1 deselected: rank held", 16'hA53C);
    endtask

    task automatic t_idle;
        step(1'b0, 1'b1, 1'b1, 1'b1, 16'h9999);
        check("R2 idle: code held", 16'hA53C);
        reveal("R2 idle: rank held", 16'hA53C);
    endtask

    task automatic t_transparent;
        step(1'b0, 1'b0, 1'b0, 1'b0, 16'h1234);
        check("R6 pass-through", 16'h1234);
        step(1'b0, 1'b0, 1'b0, 1'b0, 16'hFFFF);
        check("R6 pass-through all ones", 16'hFFFF);
        step(1'b1, 1'b1, 1'b1, 1'b1, 16'h0F0F);
        check("R6 value held after controls rise", 16'hFFFF);
        reveal("R6 rank holds bus value", 16'hFFFF);
    endtask

    task automatic t_tied;
        step(1'b0, 1'b1, 1'b0, 1'b1, 16'h0077);
        step(1'b0, 1'b0, 1'b1, 1'b0, 16'h9A00);
        check("R8 high byte with update", 16'h9A77);
        step(1'b0, 1'b0, 1'b1, 1'b1, 16'h4400);
        step(1'b0, 1'b1, 1'b0, 1'b0, 16'h0021);
        check("R8 low byte with update", 16'h4421);
    endtask

    task automatic t_reset_again;
        rst_n = 1'b0;
        step(1'b1, 1'b1, 1'b1, 1'b1, 16'h0000);
        check("R7 mid-run reset", 16'h0000);
        rst_n = 1'b1;
        reveal("R7 mid-run reset rank", 16'h0000);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_hi_byte();
                t_lo_byte();
                t_update_only();
                t_sel_block();
                t_idle();
                t_transparent();
                t_tied();
                t_reset_again();
                done = 1'b1;
            end
            begin
                repeat (5000) @(posedge clk);
                if (!done) begin
                    checks++;
                    errors++;
                    $display("FAIL watchdog expired code_out=%h expected=done", code_out);
                end
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule